// File: doc/BRIEF.md
# Half-Rate Clock Generator with Phase Stepping

This block turns a free-running oscillator of unknown duty cycle into a pair of complementary system clocks at half the oscillator rate. Both outputs come from flip-flops that update on the oscillator's rising edge only. The pair therefore has an even high/low split, and the two outputs always change together. It is meant for bring-up of slow hand-built or emulated data paths. An operator can let the clock run freely, or switch to a stepping mode in which every press of a push button moves the clock forward by one half period. This lets the high phase and the low phase be examined separately. A level-sensitive freeze input stops the clock in whichever phase it is in.

The two push buttons (step and mode) are synchronised and debounced inside the block, and each accepted press produces exactly one action. After an asynchronous reset, a start-up pulse holds the clocks low for a fixed number of oscillator edges. The freeze input is expected to be synchronous to the oscillator.

The control state machine has three states:
- POWERUP is entered on reset.
- It goes POWERUP→FREE when the start-up pulse ends.
- FREE→STEPPING and STEPPING→FREE are taken when a mode change is pending, the clock output is low, and the block is not frozen.

Top module: `phase_clock_gen`

## Requirements
- R1: In free-run mode with `halt_i` low, `clk_o` inverts on every rising edge of `osc_i`. It is high for exactly one oscillator period and low for exactly one, giving half the input rate at 50% duty whatever the input duty.
- R2: `clk_n_o` is always the inverse of `clk_o`, and both are updated on the same oscillator edge.
- R3: In stepping mode each accepted step press inverts `clk_o` exactly once, on the press and not on the release. Without a press, `clk_o` holds.
- R4: While `halt_i` is high, `clk_o` holds its current level in either mode, and step presses made during the freeze are discarded.
- R5: An accepted mode press requests a switch between free-run and stepping. The switch is applied on the first rising edge at which `clk_o` is low and `halt_i` is low, and that edge does not invert the clock. Stepping mode is therefore always entered with `clk_o` low. A request made while `clk_o` is high in stepping mode waits for a step press to bring it low.
- R6: A button input is accepted only after it has held a new level for `DEB_CYCLES` consecutive synchronised samples. A shorter pulse, or bouncing that never settles for that long, causes no action.
- R7: While `rst_ni` is low, `por_o`=1, `clk_o`=0 and `clk_n_o`=1. After release, `por_o` falls on the `POR_CYCLES`-th rising edge of `osc_i`, and `clk_o` stays low while `por_o` is high. The block then enters free-run mode.
- R8: A mode press made during a freeze stays pending and is applied per R5 once `halt_i` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_i | input | 1 | Raw oscillator; every register uses its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Level-held freeze, synchronous to `osc_i` |
| step_btn_i | input | 1 | Raw step push button, active high |
| mode_btn_i | input | 1 | Raw run/step mode push button, active high |
| clk_o | output | 1 | Generated clock |
| clk_n_o | output | 1 | Complement of `clk_o` |
| por_o | output | 1 | Start-up reset pulse, active high |

## Verification
A wrong state register shows up within one or two oscillator edges. A stuck FREE state keeps `clk_o` toggling after a mode press. A stuck STEPPING state leaves `clk_o` flat when free-run is expected. A missed freeze changes `clk_o` on the very next edge. Debounce and start-up counter faults appear as an extra or missing clock inversion in the press window, or as a start-up pulse whose length differs from `POR_CYCLES`. The bench counts inversions of `clk_o` at every sample point across each press and freeze window, so any of these shows at the ports.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    typedef enum logic [1:0] {
        ST_POWERUP  = 2'd0,
        ST_FREE     = 2'd1,
        ST_STEPPING = 2'd2
    } phase_state_e;

    localparam int unsigned NUM_BTN  = 2;
    localparam int unsigned BTN_STEP = 0;
    localparam int unsigned BTN_MODE = 1;

endpackage

// File: rtl/pcg_debounce.sv
module pcg_debounce #(
    parameter int unsigned DEB_CYCLES = 16
) (
    input  logic osc_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic press_o
);
    localparam int unsigned CW = $clog2(DEB_CYCLES + 1);

    logic          sync_a;
    logic          sync_b;
    logic          level_q;
    logic          level_d;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge osc_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_a  <= 1'b0;
            sync_b  <= 1'b0;
            level_q <= 1'b0;
            level_d <= 1'b0;
            run_cnt <= '0;
        end else begin
            sync_a  <= raw_i;
            sync_b  <= sync_a;
            level_d <= level_q;
            if (sync_b != level_q) begin
                if (run_cnt == CW'(DEB_CYCLES - 1)) begin
                    level_q <= sync_b;
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end

    assign press_o = level_q & ~level_d;

endmodule

// File: rtl/pcg_por.sv
module pcg_por #(
    parameter int unsigned POR_CYCLES = 64
) (
    input  logic osc_i,
    input  logic rst_ni,
    output logic por_o
);
    localparam int unsigned CW = $clog2(POR_CYCLES + 1);

    logic          active_q;
    logic [CW-1:0] edge_cnt;

    always_ff @(posedge osc_i or negedge rst_ni) begin
        if (!rst_ni) begin
            active_q <= 1'b1;
            edge_cnt <= '0;
        end else if (active_q) begin
            if (edge_cnt == CW'(POR_CYCLES - 1)) begin
                active_q <= 1'b0;
            end else begin
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end

    assign por_o = active_q;

endmodule

// File: rtl/pcg_phase_fsm.sv
module pcg_phase_fsm
    import pcg_pkg::*;
(
    input  logic         osc_i,
    input  logic         rst_ni,
    input  logic         por_i,
    input  logic         halt_i,
    input  logic         step_pulse_i,
    input  logic         mode_pulse_i,
    output logic         clk_o,
    output logic         clk_n_o,
    output phase_state_e state_o
);
    phase_state_e state_q, state_nxt;
    logic         pend_q, pend_nxt;
    logic         clk_q, clk_nxt;
    logic         clk_n_q;

    // state register
    always_ff @(posedge osc_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_POWERUP;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_nxt;
            pend_q  <= pend_nxt;
        end
    end

    // next state and next clock phase
    always_comb begin
        state_nxt = state_q;
        pend_nxt  = pend_q | mode_pulse_i;
        clk_nxt   = clk_q;
        unique case (state_q)
            ST_POWERUP: begin
                clk_nxt  = 1'b0;
                pend_nxt = 1'b0;
                if (!por_i) state_nxt = ST_FREE;
            end
            ST_FREE: begin
                if (!halt_i) begin
                    if (pend_q && !clk_q) begin
                        state_nxt = ST_STEPPING;
                        pend_nxt  = mode_pulse_i;
                    end else begin
                        clk_nxt = ~clk_q;
                    end
                end
            end
            ST_STEPPING: begin
                if (!halt_i) begin
                    if (pend_q && !clk_q) begin
                        state_nxt = ST_FREE;
                        pend_nxt  = mode_pulse_i;
                    end else if (step_pulse_i) begin
                        clk_nxt = ~clk_q;
                    end
                end
            end
            default: begin
                state_nxt = ST_POWERUP;
                clk_nxt   = 1'b0;
            end
        endcase
    end

    // output registers: both phases updated by the same edge
    always_ff @(posedge osc_i or negedge rst_ni) begin
        if (!rst_ni) begin
            clk_q   <= 1'b0;
            clk_n_q <= 1'b1;
        end else begin
            clk_q   <= clk_nxt;
            clk_n_q <= ~clk_nxt;
        end
    end

    assign clk_o   = clk_q;
    assign clk_n_o = clk_n_q;
    assign state_o = state_q;

endmodule

// File: rtl/phase_clock_gen.sv
module phase_clock_gen
    import pcg_pkg::*;
#(
    parameter int unsigned DEB_CYCLES = 50000,
    parameter int unsigned POR_CYCLES = 1024
) (
    input  logic osc_i,
    input  logic rst_ni,
    input  logic halt_i,
    input  logic step_btn_i,
    input  logic mode_btn_i,
    output logic clk_o,
    output logic clk_n_o,
    output logic por_o
);
    logic [NUM_BTN-1:0] raw_btn;
    logic [NUM_BTN-1:0] btn_press;
    logic               step_pulse;
    logic               mode_pulse;
    phase_state_e       fsm_state;

    assign raw_btn[BTN_STEP] = step_btn_i;
    assign raw_btn[BTN_MODE] = mode_btn_i;

    for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
        pcg_debounce #(
            .DEB_CYCLES(DEB_CYCLES)
        ) u_deb (
            .osc_i  (osc_i),
            .rst_ni (rst_ni),
            .raw_i  (raw_btn[b]),
            .press_o(btn_press[b])
        );
    end

    assign step_pulse = btn_press[BTN_STEP];
    assign mode_pulse = btn_press[BTN_MODE];

    pcg_por #(
        .POR_CYCLES(POR_CYCLES)
    ) u_por (
        .osc_i (osc_i),
        .rst_ni(rst_ni),
        .por_o (por_o)
    );

    pcg_phase_fsm u_fsm (
        .osc_i       (osc_i),
        .rst_ni      (rst_ni),
        .por_i       (por_o),
        .halt_i      (halt_i),
        .step_pulse_i(step_pulse),
        .mode_pulse_i(mode_pulse),
        .clk_o       (clk_o),
        .clk_n_o     (clk_n_o),
        .state_o     (fsm_state)
    );

endmodule

// File: rtl/phase_clock_gen_sva.sv
module phase_clock_gen_sva
    import pcg_pkg::*;
(
    input logic         osc_i,
    input logic         rst_ni,
    input logic         halt_i,
    input logic         clk_o,
    input logic         clk_n_o,
    input logic         por_o,
    input phase_state_e state,
    input logic         step_pulse
);
    p_free_toggles_r1: assert property (@(posedge osc_i) disable iff (!rst_ni)
        (state == ST_FREE && !halt_i && clk_o) |=> !clk_o);

    p_complement_r2: assert property (@(posedge osc_i) disable iff (!rst_ni)
        clk_n_o == !clk_o);

    p_step_needs_press_r3: assert property (@(posedge osc_i) disable iff (!rst_ni)
        (state == ST_STEPPING && !step_pulse) |=> $stable(clk_o));

    p_halt_freezes_r4: assert property (@(posedge osc_i) disable iff (!rst_ni)
        halt_i |=> $stable(clk_o));

    p_por_holds_low_r7: assert property (@(posedge osc_i) disable iff (!rst_ni)
        por_o |-> !clk_o);

endmodule

bind phase_clock_gen phase_clock_gen_sva u_sva (
    .osc_i     (osc_i),
    .rst_ni    (rst_ni),
    .halt_i    (halt_i),
    .clk_o     (clk_o),
    .clk_n_o   (clk_n_o),
    .por_o     (por_o),
    .state     (fsm_state),
    .step_pulse(step_pulse)
);

// File: tb/phase_clock_gen_tb.sv
module phase_clock_gen_tb;
    localparam int DEB = 4;
    localparam int POR = 8;
    localparam int HOLD = DEB + 10;

    logic osc = 1'b0;
    logic rst_n = 1'b0;
    logic halt = 1'b0;
    logic step_btn = 1'b0;
    logic mode_btn = 1'b0;
    logic clk_o, clk_n_o, por_o;

    int checks = 0;
    int failures = 0;

    always #5 osc = ~osc;

    phase_clock_gen #(.DEB_CYCLES(DEB), .POR_CYCLES(POR)) u_dut (
        .osc_i(osc), .rst_ni(rst_n), .halt_i(halt),
        .step_btn_i(step_btn), .mode_btn_i(mode_btn),
        .clk_o(clk_o), .clk_n_o(clk_n_o), .por_o(por_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // free-run: every sample differs from the previous one, complement holds
    task automatic check_running(input int n, input string req);
        logic prev;
        int   highs;
        prev  = clk_o;
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge osc);
            chk(clk_o != prev, req, clk_o, !prev);
            chk(clk_n_o == !clk_o, "R2", clk_n_o, !clk_o);
            if (clk_o) highs++;
            prev = clk_o;
        end
        chk(highs == n / 2, req, highs, n / 2);
    endtask

    task automatic check_frozen(input int n, input logic lvl, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge osc);
            chk(clk_o == lvl, req, clk_o, lvl);
        end
    endtask

    // press a button for hold cycles then release for gap cycles; count clk_o inversions
    task automatic press(input bit is_mode, input int hold, input int gap, output int changes);
        logic prev;
        prev    = clk_o;
        changes = 0;
        if (is_mode) mode_btn = 1'b1; else step_btn = 1'b1;
        for (int i = 0; i < hold; i++) begin
            @(negedge osc);
            if (clk_o != prev) changes++;
            prev = clk_o;
        end
        if (is_mode) mode_btn = 1'b0; else step_btn = 1'b0;
        for (int i = 0; i < gap; i++) begin
            @(negedge osc);
            if (clk_o != prev) changes++;
            prev = clk_o;
        end
    endtask

    initial begin
        repeat (100000) @(posedge osc);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int ch;
        int por_cnt;
        int exp_lvl;

        // R7 reset state
        repeat (3) @(negedge osc);
        chk(clk_o == 1'b0, "R7", clk_o, 0);
        chk(clk_n_o == 1'b1, "R7", clk_n_o, 1);
        chk(por_o == 1'b1, "R7", por_o, 1);

        // R7 start-up pulse length: high on POR-1 samples after release
        rst_n = 1'b1;
        por_cnt = 0;
        for (int i = 0; i < POR + 4; i++) begin
            @(negedge osc);
            if (por_o) begin
                por_cnt++;
                chk(clk_o == 1'b0, "R7", clk_o, 0);
            end
        end
        chk(por_cnt == POR - 1, "R7", por_cnt, POR - 1);

        // R1 R2 free run
        check_running(16, "R1");

        // R4 freeze while high, then while low
        while (clk_o != 1'b1) @(negedge osc);
        halt = 1'b1;
        check_frozen(10, 1'b1, "R4");
        halt = 1'b0;
        check_running(6, "R1");
        while (clk_o != 1'b0) @(negedge osc);
        halt = 1'b1;
        check_frozen(10, 1'b0, "R4");
        halt = 1'b0;
        check_running(6, "R1");

        // R5 enter stepping mode: ends low and flat
        press(1'b1, HOLD, HOLD, ch);
        check_frozen(10, 1'b0, "R5");

        // R3 each step press gives exactly one inversion
        exp_lvl = 0;
        for (int k = 0; k < 6; k++) begin
            press(1'b0, HOLD, HOLD, ch);
            exp_lvl = !exp_lvl;
            chk(ch == 1, "R3", ch, 1);
            chk(clk_o == exp_lvl[0], "R3", clk_o, exp_lvl);
            chk(clk_n_o == !clk_o, "R2", clk_n_o, !clk_o);
        end

        // R6 short glitches ignored
        for (int w = 1; w < DEB; w++) begin
            press(1'b0, w, HOLD, ch);
            chk(ch == 0, "R6", ch, 0);
        end
        // R6 bouncing then settled gives one inversion
        begin
            logic prev;
            prev = clk_o;
            ch = 0;
            for (int i = 0; i < 12; i++) begin
                step_btn = i[0];
                @(negedge osc);
                if (clk_o != prev) ch++;
                prev = clk_o;
            end
            step_btn = 1'b1;
            for (int i = 0; i < HOLD; i++) begin
                @(negedge osc);
                if (clk_o != prev) ch++;
                prev = clk_o;
            end
            step_btn = 1'b0;
            for (int i = 0; i < HOLD; i++) begin
                @(negedge osc);
                if (clk_o != prev) ch++;
                prev = clk_o;
            end
            chk(ch == 1, "R6", ch, 1);
        end
        // now clk_o high (6 steps + 1)

        // R4 step press during freeze discarded
        halt = 1'b1;
        press(1'b0, HOLD, HOLD, ch);
        chk(ch == 0, "R4", ch, 0);
        halt = 1'b0;
        check_frozen(10, 1'b1, "R4");

        // R5 mode request while high in stepping mode waits
        press(1'b1, HOLD, HOLD, ch);
        chk(ch == 0, "R5", ch, 0);
        check_frozen(10, 1'b1, "R5");
        // step brings it low, pending switch to free run applies
        press(1'b0, HOLD, 4, ch);
        check_running(12, "R5");

        // R8 mode press during freeze pending until release
        halt = 1'b1;
        press(1'b1, HOLD, HOLD, ch);
        chk(ch == 0, "R8", ch, 0);
        halt = 1'b0;
        repeat (4) @(negedge osc);
        check_frozen(10, 1'b0, "R8");
        press(1'b1, HOLD, 4, ch);
        check_running(10, "R5");

        // R7 asynchronous reset mid-run
        @(negedge osc);
        rst_n = 1'b0;
        #1;
        chk(clk_o == 1'b0, "R7", clk_o, 0);
        chk(clk_n_o == 1'b1, "R7", clk_n_o, 1);
        chk(por_o == 1'b1, "R7", por_o, 1);
        @(negedge osc);
        rst_n = 1'b1;
        check_frozen(POR - 1, 1'b0, "R7");
        repeat (4) @(negedge osc);
        chk(por_o == 1'b0, "R7", por_o, 0);
        check_running(8, "R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule